// File: doc/BRIEF.md
# GPIO Bank with Edge and Level Interrupts

This block is one 32-pin general-purpose I/O bank behind a small memory-mapped register port. Software sets each pin's direction, drives output values, reads back pin states, and configures per-pin interrupt detection. Each pin has a fixed capability set by two parameter masks: input-capable, output-capable, both, or neither. A pin with neither capability is a hole. It stores nothing and never reports anything.

Pad inputs are synchronized through two flops before any use. Each input-capable pin can flag a rising edge, a falling edge, either edge, a high level or a low level into a sticky status bit. Software clears a status bit by writing 1 to it. The single interrupt output is asserted while any status bit has its enable bit set.

Writes take effect at the clock edge that ends a write cycle. Reads are combinational from the addressed register.

Top module: `gpio_irq_bank`

## Requirements
- R1: After the active-low reset, every register reads 0, `pin_oe` is 0 and `irq` is 0.
- R2: The direction register is at address 0x04. A 1 makes a pin an output. Bits of pins that are not output-capable ignore writes and read 0. `pin_oe` equals the direction register.
- R3: The data register is at address 0x00. A read returns the stored drive value for pins set as outputs. For input-capable pins set as inputs, it returns the pin state two clocks after that state was applied. It returns 0 for every other pin. `pin_out` carries the stored drive value, and only output-capable bits store it.
- R4: The interrupt registers are enable at 0x20, type0 at 0x24, type1 at 0x28, type2 at 0x2C and status at 0x30. Any other address reads 0. Enable and type bits of pins that are not input-capable ignore writes and read 0.
- R5: The per-pin mode is {type2,type1,type0}. With 001 (rising), a low-to-high change sets the status bit 3 clocks after the change.
- R6: With 000 (falling), a high-to-low change sets the status bit 3 clocks after the change.
- R7: With type1=0 and type2=1 (101, and also 100), either change sets the status bit.
- R8: With 011 (high level) or 010 (low level), the status bit is set on every clock while the synchronized level is active. A clear therefore has no lasting effect until the level goes away.
- R9: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged. A new event in the same cycle wins over the clear.
- R10: `irq` is 1 exactly when some pin has both its status bit and its enable bit set.
- R11: Pins that are not input-capable never set a status bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 6 | Byte address of the register |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register |
| pin_in | input | 32 | Pad input levels, asynchronous |
| pin_out | output | 32 | Drive values for the pads |
| pin_oe | output | 32 | Output enables for the pads |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions check the following on every cycle:
- output enables never appear on pins without output capability, and direction reads never show such bits;
- status bits of non-input pins stay 0;
- a status bit falls only in a cycle in which a 1 was written to it;
- `irq` is never raised without both a set status bit and an enabled pin.

Only the bench scenarios can show the rest: the three-clock edge latency, the correct mode decode for each type combination, level re-assertion defeating a clear, and the data read mix of driven and synchronized values. The bench sweeps a walking toggle over all 32 pins in every mode.

// File: rtl/gpio_irq_pkg.sv
// Package: address offsets and interrupt mode codes shared by the GPIO bank,
// its checker and its bench. Assumes a 6-bit byte address space.
package gpio_irq_pkg;
    // value window
    localparam int OFS_DATA = 'h00;
    localparam int OFS_DIR  = 'h04;
    // interrupt window, base 0x20
    localparam int OFS_EN   = 'h20;
    localparam int OFS_T0   = 'h24;
    localparam int OFS_T1   = 'h28;
    localparam int OFS_T2   = 'h2C;
    localparam int OFS_STAT = 'h30;

    // per-pin mode as {type2,type1,type0}
    typedef enum logic [2:0] {
        MODE_FALL = 3'b000,
        MODE_RISE = 3'b001,
        MODE_LOW  = 3'b010,
        MODE_HIGH = 3'b011,
        MODE_BOTH = 3'b101
    } irq_mode_e;
endpackage

// File: rtl/gpio_pin_sync.sv
// Two-flop synchronizer for the pad inputs plus one history stage.
// Assumes pin_in is asynchronous to clk; cur/prev feed edge detection.
module gpio_pin_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;
    logic [W-1:0] hist_q;

    // Purpose: move pads into the clock domain and keep last synchronized value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            hist_q <= '0;
        end else begin
            meta_q <= pin_in;
            sync_q <= meta_q;
            hist_q <= sync_q;
        end
    end

    assign cur  = sync_q;
    assign prev = hist_q;
endmodule

// File: rtl/gpio_event_detect.sv
// Per-pin event decode from synchronized value, its history and three type bits.
// type1=1 selects level (type0 picks high/low); otherwise type2=1 selects both
// edges, else type0 picks rising/falling. Purely combinational.
module gpio_event_detect #(
    parameter int W = 32
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] prev,
    input  logic [W-1:0] t0,
    input  logic [W-1:0] t1,
    input  logic [W-1:0] t2,
    output logic [W-1:0] evt
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        logic rise;
        logic fall;
        assign rise = cur[i] & ~prev[i];
        assign fall = ~cur[i] & prev[i];

        // Purpose: pick the event condition for this pin's mode.
        always_comb begin
            if (t1[i])
                evt[i] = t0[i] ? cur[i] : ~cur[i];
            else if (t2[i])
                evt[i] = rise | fall;
            else
                evt[i] = t0[i] ? rise : fall;
        end
    end
endmodule

// File: rtl/gpio_status_reg.sv
// Sticky interrupt status with write-one-to-clear. A set in the same cycle
// wins over a clear. Bits outside CAP never set.
module gpio_status_reg #(
    parameter int           W   = 32,
    parameter logic [W-1:0] CAP = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    input  logic [W-1:0] clr,
    output logic [W-1:0] stat
);
    logic [W-1:0] stat_q;

    // Purpose: hold flagged events until software clears them.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stat_q <= '0;
        else
            stat_q <= ((stat_q & ~clr) | evt) & CAP;
    end

    assign stat = stat_q;
endmodule

// File: rtl/gpio_irq_bank.sv
// GPIO bank top: register port, direction/data storage, interrupt
// configuration, read mux and combined interrupt. Assumes a single-cycle
// write strobe and combinational reads; reset is synchronous, active low.
module gpio_irq_bank
    import gpio_irq_pkg::*;
#(
    parameter int           W       = 32,
    parameter int           ADDR_W  = 6,
    parameter logic [W-1:0] IN_CAP  = 32'h0FFF_FFFF,
    parameter logic [W-1:0] OUT_CAP = 32'h3000_FFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic [W-1:0]      pin_in,
    output logic [W-1:0]      pin_out,
    output logic [W-1:0]      pin_oe,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);
    localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(OFS_DIR);
    localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(OFS_EN);
    localparam logic [ADDR_W-1:0] A_T0   = ADDR_W'(OFS_T0);
    localparam logic [ADDR_W-1:0] A_T1   = ADDR_W'(OFS_T1);
    localparam logic [ADDR_W-1:0] A_T2   = ADDR_W'(OFS_T2);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);

    logic [W-1:0] data_q, dir_q, en_q, t0_q, t1_q, t2_q;
    logic [W-1:0] stat_q;
    logic [W-1:0] cur_s, prev_s, evt;
    logic [W-1:0] clr_mask;
    logic [W-1:0] data_view;

    // Purpose: store configuration, masking bits by pin capability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            dir_q  <= '0;
            en_q   <= '0;
            t0_q   <= '0;
            t1_q   <= '0;
            t2_q   <= '0;
        end else if (bus_wr) begin
            if (bus_addr == A_DATA) data_q <= bus_wdata & OUT_CAP;
            if (bus_addr == A_DIR)  dir_q  <= bus_wdata & OUT_CAP;
            if (bus_addr == A_EN)   en_q   <= bus_wdata & IN_CAP;
            if (bus_addr == A_T0)   t0_q   <= bus_wdata & IN_CAP;
            if (bus_addr == A_T1)   t1_q   <= bus_wdata & IN_CAP;
            if (bus_addr == A_T2)   t2_q   <= bus_wdata & IN_CAP;
        end
    end

    gpio_pin_sync #(.W(W)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_in (pin_in),
        .cur    (cur_s),
        .prev   (prev_s)
    );

    gpio_event_detect #(.W(W)) u_detect (
        .cur  (cur_s),
        .prev (prev_s),
        .t0   (t0_q),
        .t1   (t1_q),
        .t2   (t2_q),
        .evt  (evt)
    );

    assign clr_mask = (bus_wr && bus_addr == A_STAT) ? bus_wdata : '0;

    gpio_status_reg #(.W(W), .CAP(IN_CAP)) u_status (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (evt),
        .clr   (clr_mask),
        .stat  (stat_q)
    );

    assign data_view = (data_q & dir_q) | (cur_s & ~dir_q & IN_CAP);

    // Purpose: return the addressed register, zero for unmapped addresses.
    always_comb begin
        case (bus_addr)
            A_DATA:  bus_rdata = data_view;
            A_DIR:   bus_rdata = dir_q;
            A_EN:    bus_rdata = en_q;
            A_T0:    bus_rdata = t0_q;
            A_T1:    bus_rdata = t1_q;
            A_T2:    bus_rdata = t2_q;
            A_STAT:  bus_rdata = stat_q;
            default: bus_rdata = '0;
        endcase
    end

    assign pin_out = data_q;
    assign pin_oe  = dir_q;
    assign irq     = |(stat_q & en_q);
endmodule

// File: rtl/gpio_irq_bank_chk.sv
// Checker for gpio_irq_bank: capability masking, write-one-to-clear and
// interrupt gating, checked on every cycle out of reset.
module gpio_irq_bank_chk
    import gpio_irq_pkg::*;
#(
    parameter int           W       = 32,
    parameter int           ADDR_W  = 6,
    parameter logic [W-1:0] IN_CAP  = '1,
    parameter logic [W-1:0] OUT_CAP = '1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [W-1:0]      bus_wdata,
    input logic [W-1:0]      bus_rdata,
    input logic [W-1:0]      pin_oe,
    input logic              irq,
    input logic [W-1:0]      stat,
    input logic [W-1:0]      en
);
    logic [W-1:0] wr_ones;
    assign wr_ones = (bus_wr && bus_addr == ADDR_W'(OFS_STAT)) ? bus_wdata : '0;

    assert_oe_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe & ~OUT_CAP) == '0);

    assert_dir_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(OFS_DIR)) |-> ((bus_rdata & ~OUT_CAP) == '0));

    assert_hole_status_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (stat & ~IN_CAP) == '0);

    assert_irq_needs_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (en != '0 && stat != '0));

    assert_clear_by_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(stat) & ~stat) & ~$past(wr_ones)) == '0));
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(
    .W(W), .ADDR_W(ADDR_W), .IN_CAP(IN_CAP), .OUT_CAP(OUT_CAP)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_oe    (pin_oe),
    .irq       (irq),
    .stat      (stat_q),
    .en        (en_q)
);

// File: tb/sim_gpio_irq_bank.sv
// Bench: reset state, register map, data/direction mixes, and a walking
// toggle over every pin in every interrupt mode with computed expectations.
module sim_gpio_irq_bank;
    import gpio_irq_pkg::*;

    localparam logic [31:0] IN_CAP  = 32'h0FFF_FFFF;
    localparam logic [31:0] OUT_CAP = 32'h3000_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out, pin_oe;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    gpio_irq_bank #(.IN_CAP(IN_CAP), .OUT_CAP(OUT_CAP)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = 6'(a); bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = 6'(a);
        #1 d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [31:0] expect_evt(logic [2:0] m, logic [31:0] o, logic [31:0] n);
        if (m[1])      return m[0] ? (o | n) : (~o | ~n);
        else if (m[2]) return o ^ n;
        else if (m[0]) return n & ~o;
        else           return o & ~n;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] r;
        logic [2:0]  modes [6];
        logic [31:0] ens   [6];
        modes = '{3'b000, 3'b001, 3'b101, 3'b100, 3'b010, 3'b011};
        ens   = '{32'hFFFF_FFFF, 32'h5555_AAAA, 32'h0000_0001, 32'hFFFF_FFFF, 32'h8000_0000, 32'h00FF_FF00};

        idle(3);
        rst_n = 1'b1;

        // R1: reset state of every register and outputs
        for (int a = 0; a < 'h34; a += 4) begin
            rd(a, r);
            chk("R1 reset read", r, 32'h0);
        end
        chk("R1 pin_oe", pin_oe, 32'h0);
        chk("R1 irq", {31'h0, irq}, 32'h0);

        // R4: register map and capability masking of interrupt config
        wr(OFS_EN, 32'hFFFF_FFFF); rd(OFS_EN, r); chk("R4 enable", r, IN_CAP);
        wr(OFS_T0, 32'hF234_5678); rd(OFS_T0, r); chk("R4 type0", r, 32'hF234_5678 & IN_CAP);
        wr(OFS_T1, 32'hC0DE_1357); rd(OFS_T1, r); chk("R4 type1", r, 32'hC0DE_1357 & IN_CAP);
        wr(OFS_T2, 32'hB00F_2468); rd(OFS_T2, r); chk("R4 type2", r, 32'hB00F_2468 & IN_CAP);
        rd('h08, r); chk("R4 unmapped 0x08", r, 32'h0);
        rd('h3C, r); chk("R4 unmapped 0x3C", r, 32'h0);
        wr(OFS_EN, 32'h0); wr(OFS_T0, 32'h0); wr(OFS_T1, 32'h0); wr(OFS_T2, 32'h0);

        // R2, R3: direction masking and data read mixing
        for (int k = 0; k < 4; k++) begin
            logic [31:0] dw, dd, pp, dexp;
            dw = 32'hFFFF_FFFF >> (k * 8);
            dd = 32'hA5A5_5A5A ^ (32'h1111_1111 * k);
            pp = 32'h1234_5678 + 32'h3C3C_C3C3 * k;
            wr(OFS_DIR, dw);
            wr(OFS_DATA, dd);
            pin_in = pp;
            idle(3);
            dexp = dw & OUT_CAP;
            rd(OFS_DIR, r);  chk("R2 dir read", r, dexp);
            chk("R2 pin_oe", pin_oe, dexp);
            chk("R3 pin_out", pin_out, dd & OUT_CAP);
            rd(OFS_DATA, r);
            chk("R3 data read", r, (dd & dexp) | (pp & ~dexp & IN_CAP));
        end
        wr(OFS_DIR, 32'h0); wr(OFS_DATA, 32'h0);
        pin_in = '0;
        idle(5);

        // R5-R8, R10, R11: walking toggle in every mode
        for (int mi = 0; mi < 6; mi++) begin
            logic [2:0]  m;
            logic [31:0] en_exp;
            m = modes[mi];
            wr(OFS_T0, {32{m[0]}});
            wr(OFS_T1, {32{m[1]}});
            wr(OFS_T2, {32{m[2]}});
            wr(OFS_EN, ens[mi]);
            en_exp = ens[mi] & IN_CAP;
            idle(4);
            for (int s = 0; s < 64; s++) begin
                logic [31:0] o, n, ex;
                o = pin_in;
                n = o ^ (32'h1 << (s % 32));
                wr(OFS_STAT, 32'hFFFF_FFFF);
                pin_in = n;
                idle(4);
                ex = expect_evt(m, o, n) & IN_CAP;
                rd(OFS_STAT, r);
                if (m[1])       chk("R8 level status", r, ex);
                else if (m[2])  chk("R7 both-edge status", r, ex);
                else if (m[0])  chk("R5 rising status", r, ex);
                else            chk("R6 falling status", r, ex);
                if (s % 32 >= 28) chk("R11 non-input pin quiet", r & ~IN_CAP, 32'h0);
                chk("R10 irq", {31'h0, irq}, {31'h0, |(ex & en_exp)});
            end
        end

        // R9: write-one-to-clear in rising mode
        wr(OFS_T1, 32'h0); wr(OFS_T2, 32'h0); wr(OFS_T0, 32'hFFFF_FFFF);
        pin_in = '0; idle(4);
        wr(OFS_STAT, 32'hFFFF_FFFF);
        pin_in = 32'h0000_00FF; idle(4);
        rd(OFS_STAT, r); chk("R9 status set", r, 32'h0000_00FF);
        wr(OFS_STAT, 32'h0000_000F);
        rd(OFS_STAT, r); chk("R9 partial clear", r, 32'h0000_00F0);
        wr(OFS_STAT, 32'h0);
        rd(OFS_STAT, r); chk("R9 zero write keeps", r, 32'h0000_00F0);

        // R8: a clear does not stick while the high level remains
        wr(OFS_T1, 32'hFFFF_FFFF);
        pin_in = 32'h0000_0008; idle(4);
        wr(OFS_STAT, 32'hFFFF_FFFF);
        rd(OFS_STAT, r); chk("R8 level persists", r, 32'h0000_0008);
        pin_in = '0; idle(4);
        wr(OFS_STAT, 32'hFFFF_FFFF);
        rd(OFS_STAT, r); chk("R8 clear after level gone", r, 32'h0);
        wr(OFS_EN, 32'h0);
        chk("R10 irq low with no enable", {31'h0, irq}, 32'h0);

        finish_run();
    end
endmodule